// File: doc/BRIEF.md
# Split-Operand 16x16 Unsigned Multiplier with Per-Position Precision

This block multiplies two unsigned 16-bit operands by splitting each into a high and a low byte. Four 8x8 units each form one byte product. The high-by-high unit carries weight 2^16, the two cross units carry weight 2^8, and the low-by-low unit carries weight 2^0. A registered adder then combines the four results into a 32-bit product. Operands enter with a valid strobe, and the result leaves with its own valid strobe a fixed number of cycles later. A new operand pair can be accepted on every cycle.

Precision is fixed at elaboration by one configuration parameter. A unit that runs approximately discards every partial-product bit a_i & b_j whose column i+j is below a drop depth. This removes both those bits and any carry they would have produced. An approximate result is therefore never larger than the exact one, and its shortfall has a fixed upper bound. The high-by-high unit is always exact, so the most significant part of the result is never degraded.

Top module: `split_mul16`

## Requirements
- R1: With configuration CFG_EXACT, every valid result p equals a*b as a full 32-bit unsigned product.
- R2: out_valid rises exactly 4 clock edges after the edge that samples in_valid high, and p is valid in that same cycle. Operand pairs presented on consecutive cycles produce results on consecutive cycles, in order.
- R3: While rst is high at a clock edge, the block clears out_valid and p to 0 at that edge, and no operand that was in flight emerges afterwards.
- R4: The four byte products are weighted as follows: a[15:8]*b[15:8] by 2^16, a[15:8]*b[7:0] and a[7:0]*b[15:8] by 2^8, and a[7:0]*b[7:0] by 1.
- R5: In every configuration the high-by-high unit is exact. When a[7:0] and b[7:0] are both zero, p equals a*b even in CFG_APX1 and CFG_APX2.
- R6: A level-1 unit discards every partial-product bit in columns 0 to K1-1, with K1 = 4 by default, and sums the rest exactly.
- R7: A level-2 unit discards every partial-product bit in columns 0 to K2-1, with K2 = 6 by default, and sums the rest exactly.
- R8: CFG_APX1 runs both cross units and the low-by-low unit at level 1. CFG_APX2 runs both cross units at level 1 and the low-by-low unit at level 2.
- R9: In an approximate configuration, p is never greater than a*b. The shortfall a*b - p is at most 25137 in CFG_APX1 and at most 25409 in CFG_APX2.
- R10: The bits of p below the low-by-low unit's drop depth are always zero: p[3:0] in CFG_APX1 and p[5:0] in CFG_APX2.
- R11: A cycle with in_valid low produces a cycle with out_valid low 4 edges later, even between valid operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair on a and b is valid this cycle |
| a | input | 16 | Unsigned multiplicand |
| b | input | 16 | Unsigned multiplier |
| out_valid | output | 1 | Product on p is valid this cycle |
| p | output | 32 | Unsigned product |

## Verification
The hardest thing to show from the ports is that each byte position runs at its own precision. A single 32-bit sum mixes the four units, so an error in one cross unit can be hidden by the overlapping weight of the other. The stimulus isolates each position by making exactly one operand byte nonzero in a and one in b, so only one unit contributes to p. It then reuses the same byte values with the low bits toggled, which shows whether the discarded columns really vanish at that position. Bubble patterns and a reset issued while results are in flight reach the pipeline states that a plain stream of operands never visits.

// File: rtl/mul16_pkg.sv
package mul16_pkg;

    parameter int unsigned HALF = 8;
    localparam int unsigned OPW  = 2 * HALF;
    localparam int unsigned PW   = 2 * HALF;
    localparam int unsigned RW   = 2 * OPW;
    localparam int unsigned NPOS = 4;
    localparam int unsigned NSTG = 4;

    typedef enum logic [1:0] {
        TRUNC_NONE,
        TRUNC_LVL1,
        TRUNC_LVL2
    } trunc_e;

    typedef enum logic [1:0] {
        CFG_EXACT,
        CFG_APX1,
        CFG_APX2
    } cfg_e;

    typedef enum logic [1:0] {
        POS_HH,
        POS_HL,
        POS_LH,
        POS_LL
    } pos_e;

    typedef struct packed {
        logic [HALF-1:0] a_hi;
        logic [HALF-1:0] a_lo;
        logic [HALF-1:0] b_hi;
        logic [HALF-1:0] b_lo;
    } op_s;

    function automatic trunc_e pick_trunc(cfg_e cfg, pos_e pos);
        trunc_e t;
        if (pos == POS_HH || cfg == CFG_EXACT) begin
            t = TRUNC_NONE;
        end else if (cfg == CFG_APX2 && pos == POS_LL) begin
            t = TRUNC_LVL2;
        end else begin
            t = TRUNC_LVL1;
        end
        return t;
    endfunction

    function automatic int unsigned drop_of(cfg_e cfg, pos_e pos,
                                            int unsigned k1, int unsigned k2);
        trunc_e t;
        int unsigned d;
        t = pick_trunc(cfg, pos);
        case (t)
            TRUNC_LVL1: d = k1;
            TRUNC_LVL2: d = k2;
            default:    d = 0;
        endcase
        return d;
    endfunction

    function automatic int unsigned pos_shift(pos_e pos);
        int unsigned s;
        case (pos)
            POS_HH:  s = 2 * HALF;
            POS_HL:  s = HALF;
            POS_LH:  s = HALF;
            default: s = 0;
        endcase
        return s;
    endfunction

    function automatic longint unsigned col_bound(int unsigned w, int unsigned k);
        longint unsigned acc;
        longint unsigned cnt;
        acc = 0;
        for (int unsigned c = 0; c < k; c++) begin
            cnt = (c < w) ? longint'(c + 1) : longint'(2 * w - 1 - c);
            acc += cnt << c;
        end
        return acc;
    endfunction

    function automatic longint unsigned total_bound(cfg_e cfg, int unsigned k1,
                                                    int unsigned k2);
        longint unsigned acc;
        acc = 0;
        for (int unsigned q = 0; q < NPOS; q++) begin
            acc += col_bound(HALF, drop_of(cfg, pos_e'(q), k1, k2))
                   << pos_shift(pos_e'(q));
        end
        return acc;
    endfunction

endpackage

// File: rtl/pp_matrix.sv
module pp_matrix
    import mul16_pkg::*;
#(
    parameter int unsigned W    = HALF,
    parameter int unsigned DROP = 0
) (
    input  logic [W-1:0]            x,
    input  logic [W-1:0]            y,
    output logic [W-1:0][2*W-1:0]   rows
);

    always_comb begin
        rows = '0;
        for (int unsigned j = 0; j < W; j++) begin
            for (int unsigned i = 0; i < W; i++) begin
                if (i + j >= DROP) begin
                    rows[j][i+j] = x[i] & y[j];
                end
            end
        end
    end

endmodule

// File: rtl/csa_chain.sv
module csa_chain
    import mul16_pkg::*;
#(
    parameter int unsigned W = HALF
) (
    input  logic [W-1:0][2*W-1:0] rows,
    output logic [2*W-1:0]        sum_v,
    output logic [2*W-1:0]        cry_v
);

    always_comb begin
        logic [2*W-1:0] s_t;
        logic [2*W-1:0] c_t;
        logic [2*W-1:0] z_t;
        s_t = rows[0];
        c_t = rows[1];
        for (int unsigned j = 2; j < W; j++) begin
            z_t = rows[j];
            {s_t, c_t} = {s_t ^ c_t ^ z_t,
                          ((s_t & c_t) | (s_t & z_t) | (c_t & z_t)) << 1};
        end
        sum_v = s_t;
        cry_v = c_t;
    end

endmodule

// File: rtl/byte_mult.sv
module byte_mult
    import mul16_pkg::*;
#(
    parameter int unsigned W    = HALF,
    parameter int unsigned DROP = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     x,
    input  logic [W-1:0]     y,
    output logic [2*W-1:0]   prod
);

    localparam int unsigned UPW = 2 * W;

    logic [W-1:0][UPW-1:0] rows;
    logic [UPW-1:0]        sum_c;
    logic [UPW-1:0]        cry_c;
    logic [UPW-1:0]        sum_q;
    logic [UPW-1:0]        cry_q;
    logic [UPW-1:0]        prod_q;

    pp_matrix #(.W(W), .DROP(DROP)) u_pp (
        .x    (x),
        .y    (y),
        .rows (rows)
    );

    csa_chain #(.W(W)) u_csa (
        .rows  (rows),
        .sum_v (sum_c),
        .cry_v (cry_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q  <= '0;
            cry_q  <= '0;
            prod_q <= '0;
        end else begin
            sum_q  <= sum_c;
            cry_q  <= cry_c;
            prod_q <= sum_q + cry_q;
        end
    end

    assign prod = prod_q;

endmodule

// File: rtl/split_mul16.sv
module split_mul16
    import mul16_pkg::*;
#(
    parameter cfg_e        CFG = CFG_EXACT,
    parameter int unsigned K1  = 4,
    parameter int unsigned K2  = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [OPW-1:0] a,
    input  logic [OPW-1:0] b,
    output logic           out_valid,
    output logic [RW-1:0]  p
);

    op_s                      op_q;
    logic [NSTG-1:0]          vld_sr;
    logic [NPOS-1:0][PW-1:0]  prods;
    logic [RW-1:0]            sum_c;
    logic [RW-1:0]            p_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= '0;
            vld_sr <= '0;
        end else begin
            op_q   <= '{a_hi: a[OPW-1:HALF], a_lo: a[HALF-1:0],
                        b_hi: b[OPW-1:HALF], b_lo: b[HALF-1:0]};
            vld_sr <= {vld_sr[NSTG-2:0], in_valid};
        end
    end

    for (genvar gq = 0; gq < NPOS; gq++) begin : g_unit
        localparam pos_e        P     = pos_e'(gq);
        localparam int unsigned DEPTH = drop_of(CFG, P, K1, K2);
        logic [HALF-1:0] xs;
        logic [HALF-1:0] ys;
        assign xs = (P == POS_HH || P == POS_HL) ? op_q.a_hi : op_q.a_lo;
        assign ys = (P == POS_HH || P == POS_LH) ? op_q.b_hi : op_q.b_lo;
        byte_mult #(.W(HALF), .DROP(DEPTH)) u_bm (
            .clk  (clk),
            .rst  (rst),
            .x    (xs),
            .y    (ys),
            .prod (prods[gq])
        );
    end

    always_comb begin
        sum_c = '0;
        for (int unsigned q = 0; q < NPOS; q++) begin
            sum_c += {{(RW-PW){1'b0}}, prods[q]} << pos_shift(pos_e'(q));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q <= '0;
        end else begin
            p_q <= sum_c;
        end
    end

    assign p         = p_q;
    assign out_valid = vld_sr[NSTG-1];

endmodule

// File: rtl/split_mul16_chk.sv
module split_mul16_chk
    import mul16_pkg::*;
#(
    parameter cfg_e        CFG = CFG_EXACT,
    parameter int unsigned K1  = 4,
    parameter int unsigned K2  = 6
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [OPW-1:0] a,
    input logic [OPW-1:0] b,
    input logic           out_valid,
    input logic [RW-1:0]  p
);

    localparam longint unsigned BOUND  = total_bound(CFG, K1, K2);
    localparam int unsigned     LOWD   = drop_of(CFG, POS_LL, K1, K2);
    localparam logic [RW-1:0]   LOWMSK = RW'((64'd1 << LOWD) - 64'd1);

    logic [2:0] since_q;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
        end else if (since_q != 3'(NSTG)) begin
            since_q <= since_q + 3'd1;
        end
    end

    assign warm = (since_q == 3'(NSTG));

    p_reset_clear_r3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && p == '0));

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        warm |-> (out_valid == $past(in_valid, 4)));

    p_exact_r1: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid && CFG == CFG_EXACT) |->
        (p == ({{OPW{1'b0}}, $past(a, 4)} * {{OPW{1'b0}}, $past(b, 4)})));

    p_no_excess_r9: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid) |->
        (p <= ({{OPW{1'b0}}, $past(a, 4)} * {{OPW{1'b0}}, $past(b, 4)})));

    p_gap_bound_r9: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid) |->
        (64'(({{OPW{1'b0}}, $past(a, 4)} * {{OPW{1'b0}}, $past(b, 4)}) - p)
         <= BOUND));

    p_msb_exact_r5: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid && $past(a[HALF-1:0], 4) == '0
              && $past(b[HALF-1:0], 4) == '0) |->
        (p == ({{OPW{1'b0}}, $past(a, 4)} * {{OPW{1'b0}}, $past(b, 4)})));

    p_low_zero_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((p & LOWMSK) == '0));

endmodule

bind split_mul16 split_mul16_chk #(.CFG(CFG), .K1(K1), .K2(K2)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .a         (a),
    .b         (b),
    .out_valid (out_valid),
    .p         (p)
);

// File: tb/sim_split_mul16.sv
module sim_split_mul16;
    import mul16_pkg::*;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic        ov0, ov1, ov2;
    logic [31:0] p0, p1, p2;

    int n_chk = 0;
    int n_bad = 0;
    int unsigned seed = 32'h1234_5678;

    always #(CLK_NS/2) clk = ~clk;

    split_mul16 #(.CFG(CFG_EXACT)) u0 (.clk(clk), .rst(rst), .in_valid(in_valid),
        .a(a), .b(b), .out_valid(ov0), .p(p0));
    split_mul16 #(.CFG(CFG_APX1)) u1 (.clk(clk), .rst(rst), .in_valid(in_valid),
        .a(a), .b(b), .out_valid(ov1), .p(p1));
    split_mul16 #(.CFG(CFG_APX2)) u2 (.clk(clk), .rst(rst), .in_valid(in_valid),
        .a(a), .b(b), .out_valid(ov2), .p(p2));

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] unit_ref(input logic [7:0] x, input logic [7:0] y,
                                             input int drop);
        logic [15:0] s = '0;
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                if (i + j >= drop && x[i] && y[j]) s += 16'(1) << (i + j);
        return s;
    endfunction

    // cfg 0 exact, 1 level-1 on cross and low, 2 level-2 on low only
    function automatic logic [31:0] ref_p(input logic [15:0] x, input logic [15:0] y,
                                          input int cfg);
        int dc = (cfg == 0) ? 0 : 4;
        int dl = (cfg == 2) ? 6 : dc;
        return ({16'd0, unit_ref(x[15:8], y[15:8], 0)} << 16)
             + ({16'd0, unit_ref(x[15:8], y[7:0], dc)} << 8)
             + ({16'd0, unit_ref(x[7:0], y[15:8], dc)} << 8)
             +  {16'd0, unit_ref(x[7:0], y[7:0], dl)};
    endfunction

    function automatic int unsigned rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    task automatic check_out(input logic [15:0] x, input logic [15:0] y,
                             input string tag);
        logic [31:0] ex = {16'd0, x} * {16'd0, y};
        chk(ov0 && ov1 && ov2, {tag, " R2 out_valid"}, {29'd0, ov0, ov1, ov2}, 32'd7);
        chk(p0 == ex, {tag, " R1 exact"}, p0, ex);
        chk(p1 == ref_p(x, y, 1), {tag, " R6 R8 level1"}, p1, ref_p(x, y, 1));
        chk(p2 == ref_p(x, y, 2), {tag, " R7 R8 level2"}, p2, ref_p(x, y, 2));
        chk(p1 <= ex && (ex - p1) <= 32'd25137, {tag, " R9 apx1 bound"}, ex - p1, 32'd25137);
        chk(p2 <= ex && (ex - p2) <= 32'd25409, {tag, " R9 apx2 bound"}, ex - p2, 32'd25409);
        chk(p1[3:0] == 4'd0 && p2[5:0] == 6'd0, {tag, " R10 low bits"},
            {p2[15:0], p1[15:0]}, 32'd0);
    endtask

    task automatic run_one(input logic [15:0] x, input logic [15:0] y, input string tag);
        @(negedge clk);
        in_valid = 1'b1; a = x; b = y;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; a = '0; b = '0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk(!ov0, {tag, " R2 not early"}, {31'd0, ov0}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        check_out(x, y, tag);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b1; a = 16'hFFFF; b = 16'hFFFF;
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk(!ov0 && !ov1 && !ov2, "R3 valid in reset", {29'd0, ov0, ov1, ov2}, 32'd0);
        chk(p0 == 0 && p1 == 0 && p2 == 0, "R3 p in reset", p0 | p1 | p2, 32'd0);
        rst = 1'b0; in_valid = 1'b0; a = '0; b = '0;
    endtask

    task automatic t_corners();
        run_one(16'h0000, 16'h0000, "zero");
        run_one(16'h0001, 16'h0001, "one");
        run_one(16'hFFFF, 16'hFFFF, "max");
        run_one(16'hFFFF, 16'h0001, "max*1");
        run_one(16'h0001, 16'hFFFF, "1*max");
        run_one(16'h000F, 16'h000F, "lowcols");
    endtask

    task automatic t_isolate();
        // R4: one byte per operand so only one unit contributes
        run_one(16'hFF00, 16'hFF00, "R4 hh");
        run_one(16'hFF00, 16'h00FF, "R4 hl");
        run_one(16'h00FF, 16'hFF00, "R4 lh");
        run_one(16'h00FF, 16'h00FF, "R4 ll");
        run_one(16'h0100, 16'h0100, "R4 hh bit");
        run_one(16'h0100, 16'h0001, "R4 hl bit");
        run_one(16'h0010, 16'h0004, "R7 col6");
        run_one(16'h0008, 16'h0002, "R6 col4");
    endtask

    task automatic t_msb();
        // R5: high-by-high stays exact in every configuration
        for (int k = 0; k < 6; k++) begin
            logic [15:0] x = {8'(rnd()) | 8'h01, 8'h00};
            logic [15:0] y = {8'(rnd()), 8'h00};
            run_one(x, y, "R5 msb");
            chk(p1 == {16'd0, x} * {16'd0, y} && p2 == p1, "R5 apx exact",
                p2, {16'd0, x} * {16'd0, y});
        end
    endtask

    task automatic t_stream(input logic [11:0] pat, input string tag);
        logic [15:0] xs [12];
        logic [15:0] ys [12];
        for (int i = 0; i < 12; i++) begin
            xs[i] = 16'(rnd());
            ys[i] = 16'(rnd());
        end
        for (int n = 0; n < 16; n++) begin
            @(negedge clk);
            if (n >= 4) begin
                chk(ov0 == pat[n-4] && ov2 == pat[n-4], {tag, " R11 R2 valid seq"},
                    {31'd0, ov0}, {31'd0, pat[n-4]});
                if (pat[n-4]) check_out(xs[n-4], ys[n-4], tag);
            end
            if (n < 12) begin
                in_valid = pat[n]; a = xs[n]; b = ys[n];
            end else begin
                in_valid = 1'b0; a = '0; b = '0;
            end
        end
    endtask

    task automatic t_flush();
        // R3: reset with results in flight drops them
        @(negedge clk);
        in_valid = 1'b1; a = 16'h1234; b = 16'h5678;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b1; a = 16'hABCD; b = 16'h0FED;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int n = 0; n < 5; n++) begin
            @(negedge clk);
            chk(!ov0 && !ov1 && !ov2, "R3 flushed", {29'd0, ov0, ov1, ov2}, 32'd0);
        end
    endtask

    initial begin
        #(CLK_NS * 100000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog R2 actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_corners();
        t_isolate();
        t_msb();
        t_stream(12'hFFF, "R2 b2b");
        t_stream(12'b101100101101, "R11 bubbles");
        for (int r = 0; r < 4; r++) t_stream(12'hFFF, "R1 random");
        t_flush();
        run_one(16'hFFFF, 16'hFFFF, "post flush");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule